// File: doc/BRIEF.md
# Fine-Resolution PWM Generator

This block produces one pulse-width-modulated output from an 8-bit period timer whose duty resolution is two bits finer than the timer itself. A 2-bit sub-cycle counter sits below the timer. Together they form a 10-bit fine count. The output is high from the start of each period until that fine count reaches the buffered 10-bit duty value. A prescaler slows the whole fine count by 1, 4 or 16 oscillator clocks per step. The duty fraction is therefore the same at every prescale ratio.

The host sets the period, the duty (an 8-bit high part and 2 fraction bits), the prescale select, the postscale select and an enable. A new duty is captured only at a period boundary, so a period already under way keeps its pulse width. Each time the timer reaches the period value, a match is counted by a postscaler. Every (postscale select + 1)-th match raises a one-clock event pulse that an interrupt controller can latch.

Top module: `fine_pwm_gen`

## Requirements
- R1: While reset is asserted, and on the first clock after it is released, `pwm_o` and `evt_o` are low.
- R2: The period lasts 4 × (`period_i` + 1) × N clocks. N is 1 for `pre_sel_i` = 00, 4 for 01, and 16 for both 10 and 11.
- R3: The duty value D is {`duty_hi_i`, `duty_lo_i`}, with `duty_lo_i` as the two least significant bits. Each period, `pwm_o` is high for the first D × N clocks and low for the rest. The period begins on the clock after the edge that first samples `en_i` high, or the clock after a period match.
- R4: A duty of zero keeps `pwm_o` low for the whole period.
- R5: A duty at or above 4 × (`period_i` + 1) keeps `pwm_o` high for the whole period.
- R6: A duty change made inside a period has no effect on that period. It is used from the next period boundary on.
- R7: `evt_o` is a one-clock pulse on the clock after every (`post_sel_i` + 1)-th period match. The start of a period caused by enabling is not a match.
- R8: One clock after `en_i` is sampled low, `pwm_o` and `evt_o` are low, and they stay low while disabled. The timer, sub-cycle, prescale and postscale counts return to zero, so re-enabling starts a fresh period and a fresh postscale count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_i | input | 1 | Run enable |
| period_i | input | 8 | Period value: the timer ends a period when it reaches this value |
| duty_hi_i | input | 8 | Upper 8 bits of the duty value |
| duty_lo_i | input | 2 | Fraction bits (LSBs) of the duty value |
| pre_sel_i | input | 2 | Prescale select: 00 → 1, 01 → 4, 1x → 16 |
| post_sel_i | input | 4 | Postscale select: event on every (value + 1)-th match |
| pwm_o | output | 1 | PWM output |
| evt_o | output | 1 | Postscaled period-match event, one-clock pulse |

## Verification
The bench predicts every clock of the output from the period length and the duty, and goes after these corner cases:
- **Zero duty.** A design that raised the output at the boundary regardless of duty would emit a one-step spike.
- **Duty exactly equal to the period count, and the maximum duty.** An off-by-one compare would drop the output for one step before the boundary.
- **Mid-period duty change.** A design without the boundary buffer would shorten or stretch the running pulse.
- **Single-step periods (period value 0) with a postscale of 16.** These catch a postscaler that counts the enable start as a match.
- **The 11 prescale code, and disabling part-way through a period.** A design that misdecoded the code or failed to clear its counts would come back with the wrong phase.

// File: rtl/fpwm_pkg.sv
// Shared types and helpers for the fine-resolution PWM generator.
// Assumes the prescale select is a 2-bit code with both upper codes meaning 1:16.
package fpwm_pkg;

    // Prescale codes; the last two both select the slowest ratio.
    typedef enum logic [1:0] {
        PRE_X1      = 2'b00,
        PRE_X4      = 2'b01,
        PRE_X16     = 2'b10,
        PRE_X16_ALT = 2'b11
    } pre_sel_e;

    // Width of the prescale counter, enough for the 1:16 ratio.
    localparam int PRE_CNT_W = 4;

    // Terminal count of the prescaler for a given select code (ratio - 1).
    function automatic logic [PRE_CNT_W-1:0] pre_limit(input logic [1:0] sel);
        logic [PRE_CNT_W-1:0] lim;
        case (pre_sel_e'(sel))
            PRE_X1:  lim = 4'd0;
            PRE_X4:  lim = 4'd3;
            default: lim = 4'd15;
        endcase
        return lim;
    endfunction

endpackage

// File: rtl/fpwm_prescaler.sv
// Prescaler: divides the oscillator clock by 1, 4 or 16 and emits a
// one-clock step pulse that advances the fine (timer + sub-cycle) count.
// Assumes run is low whenever the generator is idle; the count clears then.
module fpwm_prescaler
    import fpwm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [1:0] pre_sel,
    output logic       step_o
);

    logic [PRE_CNT_W-1:0] div_cnt;
    logic [PRE_CNT_W-1:0] div_lim;
    logic                 at_lim;

    // Decode the terminal count and flag when it is reached (>= covers a
    // ratio lowered while the counter is above the new limit).
    always_comb begin
        div_lim = pre_limit(pre_sel);
        at_lim  = (div_cnt >= div_lim);
        step_o  = run && at_lim;
    end

    // Divider counter: clears while idle, wraps at the terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n)       div_cnt <= '0;
        else if (!run)    div_cnt <= '0;
        else if (at_lim)  div_cnt <= '0;
        else              div_cnt <= div_cnt + 1'b1;
    end

    // R2: the divider never leaves a step pending across an idle cycle.
    a_r2_idle_clears_divider: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (div_cnt == '0));

endmodule

// File: rtl/fpwm_timebase.sv
// Timebase: an 8-bit period timer with a 2-bit sub-cycle counter below it,
// together forming the fine count. Both step on the prescaler pulse; the
// period ends when the sub-cycle count is at its top and the timer has
// reached the period value. Assumes en low forces an idle state.
module fpwm_timebase #(
    parameter int TMR_W  = 8,
    parameter int FRAC_W = 2,
    localparam int FINE_W = TMR_W + FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              step,
    input  logic [TMR_W-1:0]  period,
    output logic [FINE_W-1:0] fine_o,
    output logic              match_o
);

    logic [TMR_W-1:0]  tmr_q;
    logic [FRAC_W-1:0] sub_q;
    logic              last_step;

    // Detect the final fine step of the period (>= also ends a period whose
    // limit was lowered below the running timer).
    always_comb begin
        last_step = (sub_q == {FRAC_W{1'b1}}) && (tmr_q >= period);
        match_o   = step && last_step;
        fine_o    = {tmr_q, sub_q};
    end

    // Fine counter: clear when idle or at the period end, otherwise advance.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            tmr_q <= '0;
            sub_q <= '0;
        end else if (step) begin
            if (last_step) begin
                tmr_q <= '0;
                sub_q <= '0;
            end else begin
                {tmr_q, sub_q} <= {tmr_q, sub_q} + 1'b1;
            end
        end
    end

    // R8: disabling returns the fine count to zero on the next clock.
    a_r8_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (fine_o == '0));

    // R2: a non-final position never wraps to zero while enabled.
    a_r2_no_early_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (en && (fine_o != '0) && !last_step) |=> (fine_o != '0));

endmodule

// File: rtl/fpwm_duty_out.sv
// Duty stage: holds the duty value captured at each period start and drives
// the registered PWM output high while the fine count is below it.
// Assumes load pulses exactly at period starts and active marks a running
// timebase. Output lags the fine count by one clock.
module fpwm_duty_out #(
    parameter int DUTY_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              load,
    input  logic [DUTY_W-1:0] duty_in,
    input  logic [DUTY_W-1:0] fine,
    output logic              pwm_o
);

    logic [DUTY_W-1:0] duty_buf;
    logic              below;

    // Compare the running fine count with the buffered duty.
    always_comb below = (fine < duty_buf);

    // Duty buffer: capture the host value only at a period start.
    always_ff @(posedge clk) begin
        if (!rst_n)    duty_buf <= '0;
        else if (load) duty_buf <= duty_in;
    end

    // Output register: high while running and below the duty point.
    always_ff @(posedge clk) begin
        if (!rst_n) pwm_o <= 1'b0;
        else        pwm_o <= active && below;
    end

    // R6: the buffered duty changes only at a period start.
    a_r6_duty_held: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(duty_buf));

    // R4: a zero duty never lets the output rise.
    a_r4_zero_duty_low: assert property (@(posedge clk) disable iff (!rst_n)
        (duty_buf == '0) |=> !pwm_o);

    // R1: the output is low on the clock after any reset cycle.
    a_r1_reset_low: assert property (@(posedge clk)
        !rst_n |=> !pwm_o);

endmodule

// File: rtl/fpwm_postscaler.sv
// Postscaler: counts period matches and pulses the event output for one
// clock on every (sel + 1)-th match. Assumes matches are at least two clocks
// apart (a period is never shorter than four clocks).
module fpwm_postscaler #(
    parameter int POST_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              match,
    input  logic [POST_W-1:0] sel,
    output logic              evt_o
);

    logic [POST_W-1:0] match_cnt;
    logic              at_sel;

    // Flag the match that completes the selected group.
    always_comb at_sel = (match_cnt >= sel);

    // Match counter: clear when idle, wrap after the selected count.
    always_ff @(posedge clk) begin
        if (!rst_n || !en)  match_cnt <= '0;
        else if (match)     match_cnt <= at_sel ? '0 : match_cnt + 1'b1;
    end

    // Event register: one clock high for the completing match.
    always_ff @(posedge clk) begin
        if (!rst_n) evt_o <= 1'b0;
        else        evt_o <= en && match && at_sel;
    end

    // R7: the event is a single-clock pulse.
    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        evt_o |=> !evt_o);

    // R8: no event follows a disabled cycle.
    a_r8_no_evt_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !evt_o);

endmodule

// File: rtl/fine_pwm_gen.sv
// Fine-resolution PWM generator top. Wires the prescaler, the timer with
// its sub-cycle counter, the buffered duty stage and the postscaler.
// The first clock with en high starts a period and captures the duty.
// Assumes all inputs are synchronous to clk.
module fine_pwm_gen #(
    parameter int TMR_W  = 8,
    parameter int FRAC_W = 2,
    parameter int POST_W = 4,
    localparam int DUTY_W = TMR_W + FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic [TMR_W-1:0]  period_i,
    input  logic [TMR_W-1:0]  duty_hi_i,
    input  logic [FRAC_W-1:0] duty_lo_i,
    input  logic [1:0]        pre_sel_i,
    input  logic [POST_W-1:0] post_sel_i,
    output logic              pwm_o,
    output logic              evt_o
);

    logic              run_q;
    logic              active;
    logic              start;
    logic              step;
    logic              match;
    logic [DUTY_W-1:0] fine;
    logic [DUTY_W-1:0] duty_word;

    // Track whether the previous clock was enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) run_q <= 1'b0;
        else        run_q <= en_i;
    end

    // Running state, period start and the combined duty word.
    always_comb begin
        active    = en_i && run_q;
        start     = (en_i && !run_q) || match;
        duty_word = {duty_hi_i, duty_lo_i};
    end

    fpwm_prescaler u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (active),
        .pre_sel (pre_sel_i),
        .step_o  (step)
    );

    fpwm_timebase #(.TMR_W(TMR_W), .FRAC_W(FRAC_W)) u_tbase (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en_i),
        .step    (step),
        .period  (period_i),
        .fine_o  (fine),
        .match_o (match)
    );

    fpwm_duty_out #(.DUTY_W(DUTY_W)) u_duty (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (active),
        .load    (start),
        .duty_in (duty_word),
        .fine    (fine),
        .pwm_o   (pwm_o)
    );

    fpwm_postscaler #(.POST_W(POST_W)) u_post (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en_i),
        .match (match),
        .sel   (post_sel_i),
        .evt_o (evt_o)
    );

    // R7: an event only follows a period match.
    a_r7_evt_after_match: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(evt_o) |-> $past(match));

    // R8: the output is low on the clock after a disabled sample.
    a_r8_out_low_off: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !pwm_o);

endmodule

// File: tb/fine_pwm_gen_bench.sv
// Self-checking bench: predicts pwm_o and evt_o for every clock from the
// period length, duty and postscale ratio, over directed and random setups.
module fine_pwm_gen_bench;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       en;
    logic [7:0] per;
    logic [7:0] dhi;
    logic [1:0] dlo;
    logic [1:0] pre;
    logic [3:0] post;
    logic       pwm;
    logic       evt;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    always #2 clk = ~clk;

    fine_pwm_gen u_fine_pwm_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (en),
        .period_i   (per),
        .duty_hi_i  (dhi),
        .duty_lo_i  (dlo),
        .pre_sel_i  (pre),
        .post_sel_i (post),
        .pwm_o      (pwm),
        .evt_o      (evt)
    );

    // Prescale ratio from the select code (R2).
    function automatic int ratio(input int code);
        if (code == 0) return 1;
        if (code == 1) return 4;
        return 16;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic set_duty(input int d);
        dhi = 8'(d >> 2);
        dlo = 2'(d & 3);
    endtask

    // Run one enabled segment and check every clock.
    task automatic seg(input int pr, input int d, input int ps, input int pst,
                       input int ncyc, input int chg_at, input int d2);
        int n, p4, plen, bufd, dcur, lim, ph;
        bit changed, exp_o, exp_e;
        string tag;
        n    = ratio(ps);
        p4   = 4 * (pr + 1);
        plen = p4 * n;
        @(negedge clk);
        per = 8'(pr); pre = 2'(ps); post = 4'(pst);
        set_duty(d);
        en = 1'b1;
        @(posedge clk);            // enabling edge: duty captured
        bufd = d; dcur = d; changed = 1'b0;
        for (int k = 1; k <= ncyc; k++) begin
            @(posedge clk);
            @(negedge clk);
            ph    = (k - 1) % plen;
            lim   = (bufd < p4) ? bufd : p4;
            exp_o = (ph < lim * n);
            if (changed)         tag = "R6";
            else if (bufd == 0)  tag = "R4";
            else if (bufd >= p4) tag = "R5";
            else if (ps != 0)    tag = "R2";
            else                 tag = "R3";
            chk(pwm == exp_o, tag, int'(pwm), int'(exp_o));
            exp_e = ((k % plen) == 0) && (((k / plen) % (pst + 1)) == 0);
            chk(evt == exp_e, "R7", int'(evt), int'(exp_e));
            if ((k % plen) == 0) bufd = dcur;
            if (k == chg_at) begin
                dcur = d2;
                set_duty(d2);
                changed = 1'b1;
            end
        end
    endtask

    // Disable and check the outputs stay low (R8).
    task automatic off(input int ncyc);
        @(negedge clk);
        en = 1'b0;
        for (int k = 0; k < ncyc; k++) begin
            @(posedge clk);
            @(negedge clk);
            chk(pwm == 1'b0, "R8", int'(pwm), 0);
            chk(evt == 1'b0, "R8", int'(evt), 0);
        end
    endtask

    initial begin
        int pr, ps, pst, d, plen;
        void'($urandom(32'd4242));
        rst_n = 1'b0; en = 1'b1;
        per = 8'd3; pre = 2'd0; post = 4'd0; dhi = 8'd2; dlo = 2'd0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(pwm == 1'b0, "R1", int'(pwm), 0);
        chk(evt == 1'b0, "R1", int'(evt), 0);
        en = 1'b0;
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk(pwm == 1'b0, "R1", int'(pwm), 0);
        chk(evt == 1'b0, "R1", int'(evt), 0);

        seg(3, 5, 0, 0, 64, -1, 0);          off(3);   // R3 basic
        seg(3, 1, 0, 1, 64, -1, 0);          off(3);   // R3 single-step high
        seg(7, 0, 0, 0, 80, -1, 0);          off(3);   // R4 zero duty
        seg(7, 32, 0, 0, 80, -1, 0);         off(3);   // R5 duty = 4(PR+1)
        seg(9, 1023, 1, 2, 500, -1, 0);      off(3);   // R5 max duty, R2
        seg(15, 20, 0, 0, 200, 10, 50);      off(3);   // R6 raise mid-period
        seg(15, 50, 0, 1, 200, 70, 3);       off(3);   // R6 lower mid-period
        seg(0, 2, 0, 15, 140, -1, 0);        off(3);   // R7 postscale 16
        seg(3, 9, 3, 2, 820, -1, 0);         off(3);   // R2 code 11 = 1:16
        seg(2, 5, 2, 0, 300, -1, 0);         off(3);   // R2 1:16
        seg(255, 600, 0, 1, 2100, 1500, 40); off(4);   // R2 full-size period
        seg(5, 11, 0, 0, 37, -1, 0);         off(2);   // R8 stop mid-period
        seg(5, 11, 0, 1, 60, -1, 0);         off(3);   // R8 fresh restart

        for (int i = 0; i < 12; i++) begin
            ps  = int'($urandom_range(0, 3));
            pr  = (ps >= 2) ? int'($urandom_range(0, 7)) :
                  (ps == 1) ? int'($urandom_range(0, 15)) : int'($urandom_range(0, 63));
            pst = int'($urandom_range(0, 3));
            d   = int'($urandom_range(0, 4 * (pr + 1) + 4));
            plen = 4 * (pr + 1) * ratio(ps);
            seg(pr, d, ps, pst, plen * (pst + 1) * 2 + 3,
                int'($urandom_range(1, plen)), int'($urandom_range(0, 4 * (pr + 1))));
            off(2);
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 200000, 0);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule